// File: doc/BRIEF.md
# Push-Button Up/Down Code Generator

This block turns a pair of active-low push buttons into a 4-bit setting code, such as a channel number or a volume level on a hand-held remote. Both buttons pass through a two-stage synchronizer. A small state machine then samples them on a slow clock-enable tick, 80 Hz by default when divided down from a 50 MHz clock. Each new press produces a single step request together with its direction. A 4-bit up/down counter applies the request to the code.

The `sat_mode` input selects what happens at the ends of the range. When it is low the code wraps around. When it is high the code stops at its limits. When `rpt_en` is high, a button held down keeps stepping the code once per repeat interval, which is one second by default, until it is released. Pressing both buttons at once is treated as a conflict: it produces no step, and the block waits until both buttons are released.

Top module: `updown_code_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `code` is 0 and `step_en` and `step_up` are low.
- R2: With `rpt_en` low, each press gives exactly one `step_en` pulse, however long the button is held. The pulse lasts exactly one sampling period, which is TICK_DIV clock cycles (default 625000, giving 80 Hz from 50 MHz).
- R3: `step_up` is high for every cycle of a `step_en` pulse caused by the up button (`up_n` low). It stays low for a pulse caused by the down button (`dn_n` low), and it is never high while `step_en` is low.
- R4: Each step changes `code` by exactly one: +1 for an up step and -1 for a down step. The code never changes without a step.
- R5: With `sat_mode` low, an up step from 15 gives 0 and a down step from 0 gives 15.
- R6: With `sat_mode` high, an up step at 15 leaves the code at 15 and a down step at 0 leaves it at 0.
- R7: When both buttons are sampled pressed, no step is produced. No further step is produced until both buttons have been sampled released, even if one button stays pressed on its own.
- R8: With `rpt_en` high and a button held, steps keep coming, spaced exactly REPEAT_TICKS sampling periods apart (default 80, which is one second). The first repeat comes one interval after the initial step.
- R9: Once the held button is released, no further step occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| up_n | input | 1 | Up push button, active low, asynchronous |
| dn_n | input | 1 | Down push button, active low, asynchronous |
| sat_mode | input | 1 | 1: saturate at 0 and 15; 0: wrap around |
| rpt_en | input | 1 | 1: hold-to-repeat enabled |
| code | output | CODE_W (4) | Current setting code |
| step_en | output | 1 | Step strobe, one sampling period wide |
| step_up | output | 1 | Step direction, high for up steps only |

## Verification
The bench holds buttons for many sampling periods. A design that stepped on every sample instead of on each new press would show extra `step_en` edges and a code that jumps by more than one. It drives the code across both ends of its range in each mode, which catches a counter whose wrap and saturate behaviour is swapped or off by one. It presses both buttons and then releases only one, so a state machine that dropped its lockout would produce a stray step. With repeat enabled it measures the spacing between step edges and watches the code after release, which exposes an interval counter that is off by one tick or a repeat that keeps running after release.

// File: rtl/updown_code_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the press-edge state machine.
// Assumes: no other package in the code base claims these names.
package updown_code_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // no button sampled pressed
        ST_UP_STEP = 3'd1,  // one sampling period of up strobe
        ST_DN_STEP = 3'd2,  // one sampling period of down strobe
        ST_UP_HOLD = 3'd3,  // up held after its step
        ST_DN_HOLD = 3'd4,  // down held after its step
        ST_LOCKOUT = 3'd5   // conflict seen, wait for full release
    } press_state_e;

endpackage

// File: rtl/sample_tick.sv
`timescale 1ns/1ps
// Module: sample_tick
// Purpose: free-running divider that emits a single-cycle enable every
//          DIV clock cycles; it paces button sampling for the block.
// Assumes: DIV >= 2.
module sample_tick #(
    parameter int unsigned DIV = 625000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count 0..DIV-1 and restart.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // Enable is high on the last count of each period.
    assign tick = (cnt == LAST);
endmodule

// File: rtl/btn_sync.sv
`timescale 1ns/1ps
// Module: btn_sync
// Purpose: two-flop synchronizer per active-low button; outputs active-high
//          "pressed" levels in the clk domain.
// Assumes: buttons idle high; the reset value reads as released.
module btn_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] btn_n,
    output logic [N-1:0] pressed
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;

        // Two-stage capture of one asynchronous button line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
            end else begin
                s1 <= btn_n[i];
                s2 <= s1;
            end
        end

        assign pressed[i] = ~s2;
    end
endmodule

// File: rtl/press_fsm.sv
`timescale 1ns/1ps
// Module: press_fsm
// Purpose: Moore state machine that samples the synchronized buttons on
//          each tick and gives one strobe per new press, one sampling
//          period long; with repeat enabled, a held button re-strobes
//          every REPEAT_TICKS ticks.
// Assumes: REPEAT_TICKS >= 2; inputs are already synchronized.
module press_fsm
    import updown_code_pkg::*;
#(
    parameter int unsigned REPEAT_TICKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic up_p,
    input  logic dn_p,
    input  logic rpt_en,
    output logic step_en,
    output logic step_up
);
    localparam int unsigned RW = (REPEAT_TICKS > 2) ? $clog2(REPEAT_TICKS) : 1;
    localparam logic [RW-1:0] RPT_LAST = RW'(REPEAT_TICKS - 2);

    press_state_e state, state_nx;
    logic [RW-1:0] rpt_cnt;
    logic          rpt_due;

    logic both, none;
    assign both = up_p & dn_p;
    assign none = ~up_p & ~dn_p;
    assign rpt_due = rpt_en && (rpt_cnt == RPT_LAST);

    // Next-state decision, evaluated only when the tick is high.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (both)      state_nx = ST_LOCKOUT;
                else if (up_p) state_nx = ST_UP_STEP;
                else if (dn_p) state_nx = ST_DN_STEP;
            end
            ST_UP_STEP, ST_UP_HOLD: begin
                if (both)       state_nx = ST_LOCKOUT;
                else if (!up_p) state_nx = ST_IDLE;
                else if (state == ST_UP_HOLD && rpt_due) state_nx = ST_UP_STEP;
                else            state_nx = ST_UP_HOLD;
            end
            ST_DN_STEP, ST_DN_HOLD: begin
                if (both)       state_nx = ST_LOCKOUT;
                else if (!dn_p) state_nx = ST_IDLE;
                else if (state == ST_DN_HOLD && rpt_due) state_nx = ST_DN_STEP;
                else            state_nx = ST_DN_HOLD;
            end
            ST_LOCKOUT: begin
                if (none) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register, advanced on the sampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= ST_IDLE;
        else if (tick) state <= state_nx;
    end

    // Repeat interval counter: counts ticks spent in a hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_cnt <= '0;
        end else if (tick) begin
            if ((state == ST_UP_HOLD || state == ST_DN_HOLD) && rpt_en && !rpt_due)
                rpt_cnt <= rpt_cnt + 1'b1;
            else
                rpt_cnt <= '0;
        end
    end

    // Moore outputs.
    assign step_en = (state == ST_UP_STEP) || (state == ST_DN_STEP);
    assign step_up = (state == ST_UP_STEP);
endmodule

// File: rtl/code_counter.sv
`timescale 1ns/1ps
// Module: code_counter
// Purpose: W-bit up/down counter that either wraps or saturates at its ends.
// Assumes: step is a single-cycle request.
module code_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         up,
    input  logic         sat,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] MAXV = '1;

    // Apply one step, holding at the end when saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (step) begin
            if (up) begin
                if (!(sat && code == MAXV)) code <= code + 1'b1;
            end else begin
                if (!(sat && code == '0))   code <= code - 1'b1;
            end
        end
    end
endmodule

// File: rtl/updown_code_gen.sv
`timescale 1ns/1ps
// Module: updown_code_gen (top)
// Purpose: two active-low buttons -> one step per press -> CODE_W-bit code,
//          with wrap/saturate choice and optional hold-to-repeat.
// Assumes: TICK_DIV gives the sampling rate (625000 -> 80 Hz at 50 MHz);
//          REPEAT_TICKS ticks form one repeat interval (80 -> 1 s).
module updown_code_gen #(
    parameter int unsigned CODE_W       = 4,
    parameter int unsigned TICK_DIV     = 625000,
    parameter int unsigned REPEAT_TICKS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_n,
    input  logic              dn_n,
    input  logic              sat_mode,
    input  logic              rpt_en,
    output logic [CODE_W-1:0] code,
    output logic              step_en,
    output logic              step_up
);
    logic       smp_tick;
    logic [1:0] pressed;

    sample_tick #(.DIV(TICK_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (smp_tick)
    );

    btn_sync #(.N(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n   ({dn_n, up_n}),
        .pressed (pressed)
    );

    press_fsm #(.REPEAT_TICKS(REPEAT_TICKS)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (smp_tick),
        .up_p    (pressed[0]),
        .dn_p    (pressed[1]),
        .rpt_en  (rpt_en),
        .step_en (step_en),
        .step_up (step_up)
    );

    code_counter #(.W(CODE_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_en & smp_tick),
        .up    (step_up),
        .sat   (sat_mode),
        .code  (code)
    );
endmodule

// File: rtl/updown_code_gen_chk.sv
`timescale 1ns/1ps
// Module: updown_code_gen_chk
// Purpose: property checks on the top-level outputs, bound into the top.
// Assumes: reset is held low across the first clock edge.
module updown_code_gen_chk #(
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sat_mode,
    input logic              tick,
    input logic              step_en,
    input logic              step_up,
    input logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] MAXV = '1;

    // R1: reset clears the code
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> code == '0);

    // R2: the strobe only changes on a sampling tick
    p_strobe_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(step_en));

    // R3: direction never shows without a strobe
    p_dir_with_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |-> step_en);

    // R4: any code change is a single step
    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |->
            (code == CODE_W'($past(code) + 1'b1) || code == CODE_W'($past(code) - 1'b1)));

    // R5: wrap at top
    p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_mode && tick && step_en && step_up && code == MAXV) |=> code == '0);

    // R6: hold at top and bottom
    p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_mode && tick && step_en && step_up && code == MAXV) |=> code == MAXV);
    p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_mode && tick && step_en && !step_up && code == '0) |=> code == '0);
endmodule

bind updown_code_gen updown_code_gen_chk #(.CODE_W(CODE_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sat_mode (sat_mode),
    .tick     (smp_tick),
    .step_en  (step_en),
    .step_up  (step_up),
    .code     (code)
);

// File: tb/test_updown_code_gen.sv
`timescale 1ns/1ps
// Directed bench for updown_code_gen with a short tick and repeat interval.
module test_updown_code_gen;
    localparam int DIV = 4;
    localparam int REP = 6;
    localparam int SETTLE = 4 * DIV + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_n = 1'b1, dn_n = 1'b1, sat_mode = 1'b0, rpt_en = 1'b0;
    logic [3:0] code;
    logic       step_en, step_up;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    updown_code_gen #(.CODE_W(4), .TICK_DIV(DIV), .REPEAT_TICKS(REP)) i_updown_code_gen (
        .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n),
        .sat_mode(sat_mode), .rpt_en(rpt_en),
        .code(code), .step_en(step_en), .step_up(step_up)
    );

    // Strobe monitor, sampled on the falling edge.
    int   cyc = 0, edges = 0, cur_len = 0, pulse_len = 0;
    int   etime [8];
    logic prev_en = 1'b0, cur_up = 1'b0, pulse_up = 1'b0, cur_dn = 1'b1, pulse_dn = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (step_en) begin
            if (!prev_en) begin
                if (edges < 8) etime[edges] = cyc;
                edges++;
                cur_len = 1; cur_up = step_up; cur_dn = !step_up;
            end else begin
                cur_len++; cur_up &= step_up; cur_dn &= !step_up;
            end
        end else if (prev_en) begin
            pulse_len = cur_len; pulse_up = cur_up; pulse_dn = cur_dn;
        end
        prev_en = step_en;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Hold the given buttons for n sampling periods, release, then settle.
    task automatic press(input bit u, input bit d, input int ticks);
        up_n = !u; dn_n = !d;
        wait_cyc(ticks * DIV);
        up_n = 1'b1; dn_n = 1'b1;
        wait_cyc(SETTLE);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wait_cyc(5);
        check(code == 4'd0 && !step_en && !step_up, "R1 in reset", code, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check(code == 4'd0 && !step_en && !step_up, "R1 after release", code, 0);
    endtask

    task automatic t_single_up;
        edges = 0;
        press(1'b1, 1'b0, 20);
        check(edges == 1, "R2 one pulse for long up hold", edges, 1);
        check(pulse_len == DIV, "R2 pulse width", pulse_len, DIV);
        check(pulse_up, "R3 step_up during up pulse", pulse_up, 1);
        check(code == 4'd1, "R4 up adds one", code, 1);
    endtask

    task automatic t_single_dn;
        edges = 0;
        press(1'b0, 1'b1, 20);
        check(edges == 1, "R2 one pulse for long down hold", edges, 1);
        check(pulse_dn, "R3 step_up low during down pulse", pulse_dn, 1);
        check(code == 4'd0, "R4 down subtracts one", code, 0);
    endtask

    task automatic t_wrap;
        sat_mode = 1'b0;
        press(1'b0, 1'b1, 4);
        check(code == 4'd15, "R5 down from 0 wraps", code, 15);
        press(1'b1, 1'b0, 4);
        check(code == 4'd0, "R5 up from 15 wraps", code, 0);
    endtask

    task automatic t_saturate;
        sat_mode = 1'b1;
        press(1'b0, 1'b1, 4);
        check(code == 4'd0, "R6 down at 0 holds", code, 0);
        for (int i = 1; i <= 15; i++) begin
            press(1'b1, 1'b0, 4);
            check(code == 4'(i), "R4 sweep up", code, i);
        end
        press(1'b1, 1'b0, 4);
        check(code == 4'd15, "R6 up at 15 holds", code, 15);
        press(1'b0, 1'b1, 4);
        check(code == 4'd14, "R6 down leaves 15", code, 14);
        sat_mode = 1'b0;
    endtask

    task automatic t_both;
        int c0;
        c0 = int'(code);
        edges = 0;
        up_n = 1'b0; dn_n = 1'b0;
        wait_cyc(6 * DIV);
        up_n = 1'b1;              // down alone stays held
        wait_cyc(8 * DIV);
        check(edges == 0, "R7 no step on both or leftover", edges, 0);
        check(int'(code) == c0, "R7 code unchanged", code, c0);
        dn_n = 1'b1;
        wait_cyc(SETTLE);
        press(1'b0, 1'b1, 4);
        check(edges == 1, "R7 press accepted after release", edges, 1);
        check(int'(code) == ((c0 + 15) % 16), "R7 code after release", code, (c0 + 15) % 16);
    endtask

    task automatic t_repeat;
        int c0, guard;
        c0 = int'(code);
        rpt_en = 1'b1;
        edges = 0;
        up_n = 1'b0;
        guard = 0;
        while (edges < 4 && guard < 400) begin
            wait_cyc(1);
            guard++;
        end
        up_n = 1'b1;
        wait_cyc(SETTLE);
        check(edges == 4, "R8 repeat steps seen", edges, 4);
        for (int k = 1; k < 4; k++)
            check(etime[k] - etime[k-1] == REP * DIV, "R8 repeat spacing",
                  etime[k] - etime[k-1], REP * DIV);
        check(int'(code) == ((c0 + 4) % 16), "R8 code advanced", code, (c0 + 4) % 16);
        wait_cyc(3 * REP * DIV);
        check(edges == 4, "R9 no step after release", edges, 4);
        check(int'(code) == ((c0 + 4) % 16), "R9 code still", code, (c0 + 4) % 16);
        rpt_en = 1'b0;
    endtask

    initial begin
        t_reset;
        t_single_up;
        t_single_dn;
        t_wrap;
        t_saturate;
        t_both;
        t_repeat;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule